// File: doc/BRIEF.md
# Global-History Correlated Branch Direction Predictor

This block guesses whether a conditional branch will be taken by looking at how the most recent branches went. It keeps one shift register holding the outcomes of the last `HIST_W` branches. It also keeps one table of `2^HIST_W` two-bit saturating counters. The counter a branch uses is picked either by the history alone or by the history XORed with a slice of the branch PC. A static select input chooses between these two modes.

A fetch stage presents a PC on the predict port. In the same cycle it gets back the predicted direction and a snapshot of the history as it stood before this prediction. The history is then shifted with the predicted direction at once, without waiting for the branch to resolve. When the branch later resolves, the back end returns:

- the actual outcome,
- a mispredict flag,
- the saved snapshot and the PC.

The counter that made the guess is trained with the actual outcome. On a mispredict, the history is rebuilt from the snapshot plus the true outcome.

Top module: `gpred_global`

## Requirements
- R1: After reset the history is all zeros and every counter holds 01 (weakly not taken). Every prediction is therefore not taken, for any PC in either mode.
- R2: `pred_taken` is bit 1 of the counter at index I. With `hash_xor`=0, I is the current history. With `hash_xor`=1, I is the history XOR `pred_pc[PC_LSB +: HIST_W]`. History bit 0 holds the newest outcome, and 1 means taken.
- R3: `pred_ckpt` shows the history value before any update in that cycle, in the same cycle the PC is presented.
- R4: On a clock edge with `pred_valid`=1 and no mispredict repair, the history becomes `{history[HIST_W-2:0], pred_taken}`.
- R5: On a clock edge with `res_valid`=1 and `res_mispredict`=1, the history becomes `{res_ckpt[HIST_W-2:0], res_taken}`. This repair overrides a prediction made in the same cycle.
- R6: On a clock edge with `res_valid`=1, the counter at the index formed from `res_ckpt` and `res_pc` (same hash and mode as R2) steps up by one if `res_taken`=1. Otherwise it steps down by one.
- R7: Counters saturate at 11 and at 00. A strongly-taken counter therefore needs two not-taken resolutions before it predicts not taken.
- R8: When `pred_valid`=0, the history is unchanged by the predict port. When `res_valid`=0, the table is unchanged and no repair takes place, whatever the other resolve inputs hold.
- R9: If a resolve writes the same counter that a same-cycle prediction reads, the prediction uses the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hash_xor | input | 1 | Index mode: 0 history only, 1 history XOR PC slice |
| pred_valid | input | 1 | A branch is being predicted this cycle |
| pred_pc | input | PC_W | PC of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_ckpt | output | HIST_W | History before this cycle's update, kept for repair |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | PC_W | PC of the resolving branch |
| res_taken | input | 1 | Actual outcome, 1 = taken |
| res_mispredict | input | 1 | The resolving branch was mispredicted |
| res_ckpt | input | HIST_W | History snapshot returned with the branch |

## Verification
`pred_taken` and `pred_ckpt` are combinational from registered state, so they are due in the cycle the PC is presented. They are compared a quarter period after the inputs change. History shifts, repairs and counter training take effect at the next rising edge. The reference model applies them just after that edge, so the next comparison sees them exactly one cycle after the stimulus. Same-cycle read/write collisions are checked by comparing before the model's update, which reflects R9.

// File: rtl/gpred_pkg.sv
package gpred_pkg;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_WEAK_NT = 2'b01;

    typedef enum logic {
        IDX_PLAIN = 1'b0,
        IDX_XOR   = 1'b1
    } idx_mode_e;

    // Saturating two-bit step towards the observed direction.
    function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
        ctr2_t r;
        if (up) r = (c == 2'b11) ? c : c + 2'b01;
        else    r = (c == 2'b00) ? c : c - 2'b01;
        return r;
    endfunction

endpackage

// File: rtl/gpred_index.sv
module gpred_index
    import gpred_pkg::*;
#(
    parameter int HIST_W = 6,
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2
) (
    input  idx_mode_e         mode,
    input  logic [HIST_W-1:0] hist,
    input  logic [PC_W-1:0]   pc,
    output logic [HIST_W-1:0] idx
);
    localparam int PC_TOP = PC_LSB + HIST_W;

    logic [HIST_W-1:0] pc_slice;
    assign pc_slice = pc[PC_LSB +: HIST_W];

    generate
        if (PC_LSB > 0) begin : g_lo
            logic unused_lo;
            assign unused_lo = ^pc[PC_LSB-1:0];
        end
        if (PC_TOP < PC_W) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^pc[PC_W-1:PC_TOP];
        end
    endgenerate

    always_comb begin
        idx = hist;
        if (mode == IDX_XOR) idx = hist ^ pc_slice;
    end
endmodule

// File: rtl/gpred_history.sv
module gpred_history #(
    parameter int HIST_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spec_en,
    input  logic              spec_dir,
    input  logic              fix_en,
    input  logic              fix_dir,
    input  logic [HIST_W-1:0] fix_base,
    output logic [HIST_W-1:0] hist_q
);
    typedef struct packed {
        logic [HIST_W-1:0] hist;
    } hist_st_t;

    hist_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fix_en)       st_d.hist = {fix_base[HIST_W-2:0], fix_dir};
        else if (spec_en) st_d.hist = {st_q.hist[HIST_W-2:0], spec_dir};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hist_q = st_q.hist;

    p_spec_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_en && !fix_en) |=> hist_q == {$past(hist_q[HIST_W-2:0]), $past(spec_dir)});

    p_repair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fix_en |=> hist_q == {$past(fix_base[HIST_W-2:0]), $past(fix_dir)});

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!spec_en && !fix_en) |=> $stable(hist_q));
endmodule

// File: rtl/gpred_table.sv
module gpred_table
    import gpred_pkg::*;
#(
    parameter int HIST_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HIST_W-1:0] rd_idx,
    output logic              rd_taken,
    input  logic              wr_en,
    input  logic [HIST_W-1:0] wr_idx,
    input  logic              wr_dir
);
    localparam int ENTRIES = 1 << HIST_W;

    typedef struct packed {
        logic [ENTRIES-1:0][1:0] ctr;
    } tbl_st_t;

    localparam tbl_st_t TBL_RST = '{ctr: {ENTRIES{CTR_WEAK_NT}}};

    tbl_st_t st_d, st_q;
    ctr2_t   wr_old;

    assign wr_old = st_q.ctr[wr_idx];

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.ctr[wr_idx] = ctr_step(wr_old, wr_dir);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TBL_RST;
        else        st_q <= st_d;
    end

    // Read comes from the registered table: a same-cycle write is not seen.
    assign rd_taken = st_q.ctr[rd_idx][1];

    p_step_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_dir && wr_old != 2'b11)
        |=> st_q.ctr[$past(wr_idx)] == $past(wr_old) + 2'b01);

    p_step_dn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_dir && wr_old != 2'b00)
        |=> st_q.ctr[$past(wr_idx)] == $past(wr_old) - 2'b01);

    p_sat_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_dir && wr_old == 2'b11) |=> st_q.ctr[$past(wr_idx)] == 2'b11);

    p_sat_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_dir && wr_old == 2'b00) |=> st_q.ctr[$past(wr_idx)] == 2'b00);

    p_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q));
endmodule

// File: rtl/gpred_global.sv
module gpred_global
    import gpred_pkg::*;
#(
    parameter int HIST_W = 6,
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hash_xor,
    input  logic              pred_valid,
    input  logic [PC_W-1:0]   pred_pc,
    output logic              pred_taken,
    output logic [HIST_W-1:0] pred_ckpt,
    input  logic              res_valid,
    input  logic [PC_W-1:0]   res_pc,
    input  logic              res_taken,
    input  logic              res_mispredict,
    input  logic [HIST_W-1:0] res_ckpt
);
    idx_mode_e         mode;
    logic [HIST_W-1:0] hist;
    logic [HIST_W-1:0] rd_idx;
    logic [HIST_W-1:0] wr_idx;
    logic              repair;

    assign mode   = idx_mode_e'(hash_xor);
    assign repair = res_valid && res_mispredict;

    gpred_index #(.HIST_W(HIST_W), .PC_W(PC_W), .PC_LSB(PC_LSB)) u_idx_rd (
        .mode(mode), .hist(hist), .pc(pred_pc), .idx(rd_idx)
    );

    gpred_index #(.HIST_W(HIST_W), .PC_W(PC_W), .PC_LSB(PC_LSB)) u_idx_wr (
        .mode(mode), .hist(res_ckpt), .pc(res_pc), .idx(wr_idx)
    );

    gpred_table #(.HIST_W(HIST_W)) u_tbl (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(rd_idx), .rd_taken(pred_taken),
        .wr_en(res_valid), .wr_idx(wr_idx), .wr_dir(res_taken)
    );

    gpred_history #(.HIST_W(HIST_W)) u_hist (
        .clk(clk), .rst_n(rst_n),
        .spec_en(pred_valid), .spec_dir(pred_taken),
        .fix_en(repair), .fix_dir(res_taken), .fix_base(res_ckpt),
        .hist_q(hist)
    );

    assign pred_ckpt = hist;

    p_ckpt_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && !repair) |=> pred_ckpt[0] == $past(pred_taken));
endmodule

// File: tb/sim_gpred_global.sv
module sim_gpred_global;
    localparam int CLK_PER = 10;
    localparam int HW      = 6;
    localparam int PW      = 32;
    localparam int PL      = 2;
    localparam int N_ENT   = 1 << HW;
    localparam int MASK    = N_ENT - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hash_xor = 1'b0;
    logic          pred_valid = 1'b0;
    logic [PW-1:0] pred_pc = '0;
    logic          pred_taken;
    logic [HW-1:0] pred_ckpt;
    logic          res_valid = 1'b0;
    logic [PW-1:0] res_pc = '0;
    logic          res_taken = 1'b0;
    logic          res_mispredict = 1'b0;
    logic [HW-1:0] res_ckpt = '0;

    int n_chk = 0;
    int n_bad = 0;
    int m_hist;
    int m_ctr [N_ENT];

    always #(CLK_PER/2) clk = ~clk;

    gpred_global #(.HIST_W(HW), .PC_W(PW), .PC_LSB(PL)) u0 (
        .clk(clk), .rst_n(rst_n), .hash_xor(hash_xor),
        .pred_valid(pred_valid), .pred_pc(pred_pc),
        .pred_taken(pred_taken), .pred_ckpt(pred_ckpt),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_mispredict(res_mispredict), .res_ckpt(res_ckpt)
    );

    function automatic int m_index(int h, logic [PW-1:0] pc, logic x);
        int s;
        s = int'((pc >> PL) & MASK);
        return x ? ((h ^ s) & MASK) : (h & MASK);
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_hist = 0;
        for (int i = 0; i < N_ENT; i++) m_ctr[i] = 1;
    endtask

    // Inputs already driven; compare outputs, cross the edge, update model.
    task automatic cycle(string tag);
        int exp_t;
        int wi;
        #(CLK_PER/4);
        exp_t = (m_ctr[m_index(m_hist, pred_pc, hash_xor)] >= 2) ? 1 : 0;
        check({tag, " R2 pred_taken"}, int'(pred_taken), exp_t);
        check({tag, " R3 pred_ckpt"}, int'(pred_ckpt), m_hist);
        @(posedge clk);
        if (res_valid) begin
            wi = m_index(int'(res_ckpt), res_pc, hash_xor);
            if (res_taken) m_ctr[wi] = (m_ctr[wi] == 3) ? 3 : m_ctr[wi] + 1;
            else           m_ctr[wi] = (m_ctr[wi] == 0) ? 0 : m_ctr[wi] - 1;
        end
        if (res_valid && res_mispredict)
            m_hist = ((int'(res_ckpt) << 1) | int'(res_taken)) & MASK;
        else if (pred_valid)
            m_hist = ((m_hist << 1) | exp_t) & MASK;
        @(negedge clk);
    endtask

    task automatic drive(logic pv, logic [PW-1:0] ppc, logic rv, logic [PW-1:0] rpc,
                         logic rt, logic rm, logic [HW-1:0] rc);
        pred_valid = pv; pred_pc = ppc; res_valid = rv; res_pc = rpc;
        res_taken = rt; res_mispredict = rm; res_ckpt = rc;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state seen across many PCs in both modes
        for (int m = 0; m < 2; m++) begin
            hash_xor = m[0];
            for (int p = 0; p < N_ENT; p++) begin
                drive(1'b0, PW'(p << PL), 1'b0, '0, 1'b0, 1'b0, '0);
                #(CLK_PER/4);
                check("R1 reset taken", int'(pred_taken), 0);
                check("R1 reset ckpt", int'(pred_ckpt), 0);
                #(CLK_PER/4);
            end
        end
        // R6 R7: train one counter up past saturation, then down twice
        hash_xor = 1'b0;
        for (int i = 0; i < 4; i++) begin
            drive(1'b0, '0, 1'b1, '0, 1'b1, 1'b0, '0);
            cycle("R6 R7 train up");
        end
        drive(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, '0);
        cycle("R7 strong taken");
        for (int i = 0; i < 3; i++) begin
            drive(1'b0, '0, 1'b1, '0, 1'b0, 1'b0, '0);
            cycle("R7 train down");
        end
        for (int i = 0; i < 3; i++) begin
            drive(1'b0, '0, 1'b1, '0, 1'b0, 1'b0, '0);
            cycle("R7 floor");
        end
        // R4: speculative shifts with taken-biased entries
        for (int i = 0; i < N_ENT; i++) begin
            drive(1'b0, '0, 1'b1, '0, 1'b1, 1'b0, HW'(i));
            cycle("R6 bias");
        end
        for (int i = 0; i < 10; i++) begin
            drive(1'b1, PW'(i * 4), 1'b0, '0, 1'b0, 1'b0, '0);
            cycle("R4 spec shift");
        end
        // R5: repair overriding a same-cycle prediction
        drive(1'b1, 32'h40, 1'b1, 32'h80, 1'b0, 1'b1, 6'h2A);
        cycle("R5 repair");
        drive(1'b1, 32'h44, 1'b1, 32'h84, 1'b1, 1'b1, 6'h15);
        cycle("R5 repair");
        drive(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, '0);
        cycle("R5 after");
        // R8: idle ports with busy side inputs
        for (int i = 0; i < 8; i++) begin
            drive(1'b0, PW'($urandom), 1'b0, PW'($urandom), 1'(i), 1'b1, HW'($urandom));
            cycle("R8 idle");
        end
        // R2 XOR mode and R9 same-index collision
        hash_xor = 1'b1;
        for (int i = 0; i < 16; i++) begin
            drive(1'b1, PW'(i << PL), 1'b1, PW'(i << PL), 1'b0, 1'b0, pred_ckpt);
            cycle("R9 collide");
        end
        // Mixed random traffic in both modes
        for (int i = 0; i < 2500; i++) begin
            if (i % 500 == 0) hash_xor = ~hash_xor;
            drive(1'($urandom), PW'($urandom), 1'($urandom), PW'($urandom),
                  1'($urandom), 1'(($urandom % 4) == 0), HW'($urandom));
            cycle("R2 R4 R5 R6 random");
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule